// File: doc/BRIEF.md
# Carry-Chain Identity Comparator

This block decides whether two operands of equal width are identical or differ. A parameter picks which of the two results the block produces. It is purely combinational. It is built the way an FPGA technology mapper would build it: small truth-table cells feed a ripple of 2:1 carry multiplexers.

For one or two bit pairs, a single table cell produces the result directly. For wider operands, the bits are grouped into two-pair slices starting from bit 0. Each slice has a table cell that always tests its slice for equality. That cell output selects the slice's carry multiplexer.

The chain constants are tied according to the mode, so the top of the chain gives either the equality result or the inequality result. No inverter is placed on the output. The block suits wide compares in which the result must not cost an extra cell at the end of the chain.

Top module: `idcmp_chain`

## Requirements
- R1: With WIDTH 1, q_o comes from one 2-input cell with table 4'h9 (EQ) or 4'h6 (NE). The cell index is {b_i[0], a_i[0]}, so q_o is a_i[0]==b_i[0] in EQ mode and a_i[0]!=b_i[0] in NE mode.
- R2: With WIDTH 2, q_o comes from one 4-input cell with table 16'h9009 (EQ) or 16'h6FF6 (NE). The cell index is {b_i[1], a_i[1], b_i[0], a_i[0]}.
- R3: With WIDTH 3 or more in EQ mode, q_o is 1 exactly when a_i equals b_i.
- R4: With WIDTH 3 or more in NE mode, q_o is 1 exactly when a_i differs from b_i. This result comes from tying every DI input to 1 and the lowest carry-in to 0, with no output inverter.
- R5: With odd WIDTH of 3 or more, the top slice holds the single bit pair WIDTH-1. It is tested by a 2-input cell, and a mismatch in that bit alone decides the result.
- R6: In chain mode, a single differing bit at any position from 0 to WIDTH-1 gives q_o 0 in EQ mode and 1 in NE mode. This holds when every other bit matches.
- R7: In chain mode, once a slice's carry output takes the DI value (0 in EQ mode, 1 in NE mode), every higher carry output holds that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| q_o | output | 1 | Identity result: equal in EQ mode, unequal in NE mode |

## Verification
Two effects can meet in a single evaluation. A mismatch in a low slice forces the DI value into the chain. An equal upper slice then has to pass that value on unchanged instead of restoring the carry-in constant.

The bench provokes this with sweeps that place differences in low bits while the high bits match, and the reverse. It also flips one bit at a time across a 17-bit operand. Each result is judged against the arithmetic equality of the masked operands.

// File: rtl/idcmp_pkg.sv
package idcmp_pkg;
  typedef enum logic {CMP_EQ = 1'b0, CMP_NE = 1'b1} cmp_mode_e;

  localparam logic [3:0]  TBL2_EQ = 4'h9;
  localparam logic [3:0]  TBL2_NE = 4'h6;
  localparam logic [15:0] TBL4_EQ = 16'h9009;
  localparam logic [15:0] TBL4_NE = 16'h6FF6;
endpackage

// File: rtl/idcmp_lut.sv
module idcmp_lut #(
  parameter int                   N    = 2,
  parameter logic [(1<<N)-1:0]    INIT = '0
) (
  input  logic [N-1:0] in_i,
  output logic         o_o
);
  assign o_o = INIT[in_i];
endmodule

// File: rtl/idcmp_cmux.sv
module idcmp_cmux (
  input  logic sel_i,
  input  logic ci_i,
  input  logic di_i,
  output logic co_o
);
  assign co_o = sel_i ? ci_i : di_i;
endmodule

// File: rtl/idcmp_chain.sv
module idcmp_chain
  import idcmp_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter cmp_mode_e MODE  = CMP_EQ
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             q_o
);
  localparam int   NSLICE = (WIDTH + 1) / 2;
  localparam logic IS_EQ  = (MODE == CMP_EQ);
  localparam logic DI_VAL = ~IS_EQ;   // value an unequal slice forces
  localparam logic CI_VAL = IS_EQ;    // chain seed

  if (WIDTH < 1) begin : g_bad_width
    $error("idcmp_chain: WIDTH must be at least 1");
  end

  if (WIDTH == 1) begin : g_w1
    idcmp_lut #(.N(2), .INIT(IS_EQ ? TBL2_EQ : TBL2_NE)) u_lut (
      .in_i({b_i[0], a_i[0]}),
      .o_o (q_o)
    );
  end else if (WIDTH == 2) begin : g_w2
    idcmp_lut #(.N(4), .INIT(IS_EQ ? TBL4_EQ : TBL4_NE)) u_lut (
      .in_i({b_i[1], a_i[1], b_i[0], a_i[0]}),
      .o_o (q_o)
    );
    always_comb begin
      // R2
      single_chk: assert (q_o == (IS_EQ ? (a_i[1:0] == b_i[1:0]) : (a_i[1:0] != b_i[1:0])))
        else $error("two-pair cell result wrong");
    end
  end else begin : g_chain
    logic [NSLICE:0]   carry;
    logic [NSLICE-1:0] sel;
    assign carry[0] = CI_VAL;

    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
      if (2*k + 1 < WIDTH) begin : g_pair2
        idcmp_lut #(.N(4), .INIT(TBL4_EQ)) u_lut (
          .in_i({b_i[2*k+1], a_i[2*k+1], b_i[2*k], a_i[2*k]}),
          .o_o (sel[k])
        );
        always_comb begin
          // R3
          sel2_chk: assert (sel[k] == ((a_i[2*k+1] ~^ b_i[2*k+1]) & (a_i[2*k] ~^ b_i[2*k])))
            else $error("slice %0d select wrong", k);
        end
      end else begin : g_pair1
        idcmp_lut #(.N(2), .INIT(TBL2_EQ)) u_lut (
          .in_i({b_i[2*k], a_i[2*k]}),
          .o_o (sel[k])
        );
        always_comb begin
          // R5
          sel1_chk: assert (sel[k] == (a_i[2*k] ~^ b_i[2*k]))
            else $error("top single slice select wrong");
        end
      end

      idcmp_cmux u_mux (
        .sel_i(sel[k]),
        .ci_i (carry[k]),
        .di_i (DI_VAL),
        .co_o (carry[k+1])
      );

      always_comb begin
        // R7
        stick_chk: assert (carry[k] != DI_VAL || carry[k+1] == DI_VAL)
          else $error("chain released forced value at slice %0d", k);
      end
    end

    assign q_o = carry[NSLICE];
  end

  always_comb begin
    // R1 R3 R4
    result_chk: assert (q_o == (IS_EQ ? (a_i == b_i) : (a_i != b_i)))
      else $error("identity result wrong");
  end
endmodule

// File: tb/idcmp_chain_test.sv
`timescale 1ns/1ps
module idcmp_chain_test;
  import idcmp_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [16:0] a = '0, b = '0;
  int errors = 0, checks = 0;
  logic done = 1'b0;

  logic q1e, q1n, q2e, q2n, q3e, q3n, q4e, q4n, q5e, q5n, q17e, q17n;

  idcmp_chain #(.WIDTH(1), .MODE(CMP_EQ)) u_w1e (.a_i(a[0:0]), .b_i(b[0:0]), .q_o(q1e));
  idcmp_chain #(.WIDTH(1), .MODE(CMP_NE)) u_w1n (.a_i(a[0:0]), .b_i(b[0:0]), .q_o(q1n));
  idcmp_chain #(.WIDTH(2), .MODE(CMP_EQ)) u_w2e (.a_i(a[1:0]), .b_i(b[1:0]), .q_o(q2e));
  idcmp_chain #(.WIDTH(2), .MODE(CMP_NE)) u_w2n (.a_i(a[1:0]), .b_i(b[1:0]), .q_o(q2n));
  idcmp_chain #(.WIDTH(3), .MODE(CMP_EQ)) u_w3e (.a_i(a[2:0]), .b_i(b[2:0]), .q_o(q3e));
  idcmp_chain #(.WIDTH(3), .MODE(CMP_NE)) u_w3n (.a_i(a[2:0]), .b_i(b[2:0]), .q_o(q3n));
  idcmp_chain #(.WIDTH(4), .MODE(CMP_EQ)) u_w4e (.a_i(a[3:0]), .b_i(b[3:0]), .q_o(q4e));
  idcmp_chain #(.WIDTH(4), .MODE(CMP_NE)) u_w4n (.a_i(a[3:0]), .b_i(b[3:0]), .q_o(q4n));
  idcmp_chain #(.WIDTH(5), .MODE(CMP_EQ)) uut   (.a_i(a[4:0]), .b_i(b[4:0]), .q_o(q5e));
  idcmp_chain #(.WIDTH(5), .MODE(CMP_NE)) u_w5n (.a_i(a[4:0]), .b_i(b[4:0]), .q_o(q5n));
  idcmp_chain #(.WIDTH(17), .MODE(CMP_EQ)) u_w17e (.a_i(a), .b_i(b), .q_o(q17e));
  idcmp_chain #(.WIDTH(17), .MODE(CMP_NE)) u_w17n (.a_i(a), .b_i(b), .q_o(q17n));

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h got=%b exp=%b", req, a, b, got, exp);
    end
  endtask

  function automatic logic same(input int w);
    logic [16:0] m;
    m = (17'h1 << w) - 17'h1;
    if (w == 17) m = '1;
    return ((a & m) == (b & m));
  endfunction

  task automatic check_all();
    chk("R1 w1 eq", q1e, same(1));
    chk("R1 w1 ne", q1n, !same(1));
    chk("R2 w2 eq", q2e, same(2));
    chk("R2 w2 ne", q2n, !same(2));
    chk("R3 R5 w3 eq", q3e, same(3));
    chk("R4 R5 w3 ne", q3n, !same(3));
    chk("R3 w4 eq", q4e, same(4));
    chk("R4 w4 ne", q4n, !same(4));
    chk("R3 R5 w5 eq", q5e, same(5));
    chk("R4 R5 w5 ne", q5n, !same(5));
    chk("R3 w17 eq", q17e, same(17));
    chk("R4 w17 ne", q17n, !same(17));
  endtask

  task automatic apply(input logic [16:0] va, input logic [16:0] vb);
    @(negedge clk);
    a = va;
    b = vb;
    #1;
    check_all();
  endtask

  initial begin
    // all-zero operands first
    apply('0, '0);
    // exhaustive over five bit pairs: R1 R2 R3 R4 R5 R7
    for (int i = 0; i < 1024; i++) begin
      apply({12'h000, i[4:0]}, {12'h000, i[9:5]});
    end
    // R6: one differing bit, every position, from zero and all-ones bases
    for (int p = 0; p < 17; p++) begin
      apply('0, 17'h1 << p);
      apply('1, ~(17'h1 << p));
      chk("R6 w17 eq single flip", q17e, 1'b0);
      chk("R6 w17 ne single flip", q17n, 1'b1);
    end
    // R5: top odd pair alone differs
    apply(17'h0FFFF, 17'h1FFFF);
    chk("R5 top pair eq", q17e, 1'b0);
    chk("R5 top pair ne", q17n, 1'b1);
    // R7: low slice differs, upper slices equal
    apply(17'h1AAA9, 17'h1AAAA);
    chk("R7 low mismatch eq", q17e, 1'b0);
    chk("R7 low mismatch ne", q17n, 1'b1);
    // random wide vectors, half equal
    for (int r = 0; r < 2000; r++) begin
      logic [16:0] ra, rb;
      ra = 17'($urandom);
      rb = r[0] ? ra : (ra ^ (17'h1 << ($urandom % 17)) ^ (r[1] ? 17'($urandom) : 17'h0));
      apply(ra, rb);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got=hang exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule